// File: doc/BRIEF.md
# Instruction cycle cost accumulator

This unit sits beside a simple in-order core and keeps the run's performance totals. Each time the core retires an instruction, it pulses a retire strobe. With the strobe it supplies a pre-decoded instruction class, a flag that says whether a control-flow instruction was taken, and a flag that says whether that control-flow instruction carries a delay slot. The unit adds one to an instruction counter. It also adds the instruction's cost to a cycle counter.

The cost of an instruction is built from a fixed table. Every instruction pays a base cycle. Certain classes pay a fixed extra charge. A taken jump pays extra, and more again if it has no delay slot. An instruction that sits in a delay slot retires on its own strobe and is charged by its own class, like any other instruction. Both counters wrap at their width. A synchronous clear zeroes them. The reported cycle total adds a fixed start-up overhead of two cycles to the raw sum, but only once anything has been counted.

Top module: `pcost_accum`

## Requirements
- R1: Each clock with `retire` high adds exactly 1 to `inst_count`. A retire of class 0 (plain ALU) adds exactly 1 to `cycle_raw`.
- R2: Class 1 (load) and class 2 (store) each add 2 to `cycle_raw`.
- R3: Class 3 (multiply), class 4 (barrel shift) and class 5 (custom extension) each add 2 to `cycle_raw`.
- R4: Class 6 (divide) adds 34 to `cycle_raw`.
- R5: Class 7 (branch or return) adds 1 when `taken` is 0. It adds 2 when taken with `has_slot` = 1, and 3 when taken with `has_slot` = 0.
- R6: For classes 0 to 6 the `taken` and `has_slot` inputs have no effect on the amount added.
- R7: `cycle_report` equals `cycle_raw` + 2 (modulo 2^CNT_W) when `cycle_raw` is nonzero, and 0 when `cycle_raw` is zero.
- R8: `clr` high at a clock edge zeroes both counters and takes priority over a simultaneous retire.
- R9: `rst_n` low at a clock edge zeroes both counters.
- R10: With `retire` and `clr` low, both counters hold their values.
- R11: Both counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous counter clear |
| retire | input | 1 | One instruction retires this clock |
| iclass | input | 3 | Instruction class code (0 ALU, 1 load, 2 store, 3 mul, 4 shift, 5 custom, 6 div, 7 branch/return) |
| taken | input | 1 | Control-flow instruction was taken |
| has_slot | input | 1 | Taken control-flow instruction has a delay slot |
| inst_count | output | CNT_W | Retired-instruction total |
| cycle_raw | output | CNT_W | Accumulated cycle cost |
| cycle_report | output | CNT_W | Reported cycle total with start-up overhead |

## Verification
A wrong entry in the cost table does not stay hidden. It shows on `cycle_raw` on the clock after the single retire of that class, and it stays as a lasting offset in every later total. So each class and each branch outcome is retired alone, and the sum is compared after every step. A counter that fails to hold, to clear, or to wrap shows up on the first idle cycle, on the first clear, or on the first step past the top value. The report offset shows up at once against the raw count.

// File: rtl/pcost_pkg.sv
// Shared class encoding and cost constants for the cycle cost accumulator.
package pcost_pkg;
    typedef enum logic [2:0] {
        CLS_ALU    = 3'd0,
        CLS_LOAD   = 3'd1,
        CLS_STORE  = 3'd2,
        CLS_MUL    = 3'd3,
        CLS_SHIFT  = 3'd4,
        CLS_CUSTOM = 3'd5,
        CLS_DIV    = 3'd6,
        CLS_FLOW   = 3'd7
    } iclass_e;

    localparam int unsigned BASE_COST    = 1;
    localparam int unsigned MEM_EXTRA    = 1;
    localparam int unsigned ARITH_EXTRA  = 1;
    localparam int unsigned DIV_EXTRA    = 33;
    localparam int unsigned TAKEN_EXTRA  = 1;
    localparam int unsigned NOSLOT_EXTRA = 1;
    localparam int unsigned REPORT_BIAS  = 2;
    localparam int unsigned MAX_COST     = BASE_COST + DIV_EXTRA;
    localparam int unsigned COST_W       = $clog2(MAX_COST + 1);
endpackage

// File: rtl/pcost_lookup.sv
// Cost lookup: turns a retired instruction's class and branch outcome
// into the number of cycles it is charged. Purely combinational.
// Assumes the class code is already decoded; the flags matter only for flow class.
module pcost_lookup
    import pcost_pkg::*;
(
    input  logic [2:0]        cls_i,
    input  logic              taken_i,
    input  logic              slot_i,
    output logic [COST_W-1:0] cost_o
);
    // Select the per-class charge.
    always_comb begin
        unique case (iclass_e'(cls_i))
            CLS_ALU:    cost_o = COST_W'(BASE_COST);
            CLS_LOAD,
            CLS_STORE:  cost_o = COST_W'(BASE_COST + MEM_EXTRA);
            CLS_MUL,
            CLS_SHIFT,
            CLS_CUSTOM: cost_o = COST_W'(BASE_COST + ARITH_EXTRA);
            CLS_DIV:    cost_o = COST_W'(BASE_COST + DIV_EXTRA);
            CLS_FLOW: begin
                if (!taken_i)
                    cost_o = COST_W'(BASE_COST);
                else if (slot_i)
                    cost_o = COST_W'(BASE_COST + TAKEN_EXTRA);
                else
                    cost_o = COST_W'(BASE_COST + TAKEN_EXTRA + NOSLOT_EXTRA);
            end
            default:    cost_o = COST_W'(BASE_COST);
        endcase
    end
endmodule

// File: rtl/pcost_counter.sv
// Wrapping accumulator: adds inc_i when en_i is high. It clears on reset
// or on clr_i, and clr_i wins over en_i.
// Assumes at most one increment per clock.
module pcost_counter #(
    parameter int unsigned W     = 32,
    parameter int unsigned INC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [W-1:0]     count_o
);
    // Accumulate modulo 2^W, with clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            count_o <= '0;
        else if (en_i)
            count_o <= count_o + W'(inc_i);
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(count_o));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));

    assert_wrap_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && en_i) |=> (count_o == W'($past(count_o) + W'($past(inc_i)))));
endmodule

// File: rtl/pcost_report.sv
// Report stage: adds the fixed start-up overhead to a nonzero raw total.
// A zero raw total is reported as zero. Combinational.
module pcost_report
    import pcost_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] report_o
);
    localparam logic [W-1:0] BIAS = W'(REPORT_BIAS);

    // Bias a nonzero total; pass zero through.
    always_comb begin
        if (raw_i == '0)
            report_o = '0;
        else
            report_o = raw_i + BIAS;
    end
endmodule

// File: rtl/pcost_accum.sv
// Instruction cycle cost accumulator top. It counts retired instructions
// and charges each one a table-driven cycle cost.
// Assumes at most one retire per clock; rst_n and clr are synchronous.
module pcost_accum
    import pcost_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             retire,
    input  logic [2:0]       iclass,
    input  logic             taken,
    input  logic             has_slot,
    output logic [CNT_W-1:0] inst_count,
    output logic [CNT_W-1:0] cycle_raw,
    output logic [CNT_W-1:0] cycle_report
);
    logic [COST_W-1:0] cost;

    pcost_lookup u_lookup (
        .cls_i   (iclass),
        .taken_i (taken),
        .slot_i  (has_slot),
        .cost_o  (cost)
    );

    pcost_counter #(.W(CNT_W), .INC_W(1)) u_inst (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .en_i    (retire),
        .inc_i   (1'b1),
        .count_o (inst_count)
    );

    pcost_counter #(.W(CNT_W), .INC_W(COST_W)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .en_i    (retire),
        .inc_i   (cost),
        .count_o (cycle_raw)
    );

    pcost_report #(.W(CNT_W)) u_rep (
        .raw_i    (cycle_raw),
        .report_o (cycle_report)
    );

    assert_inst_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !clr) |=> (inst_count == CNT_W'($past(inst_count) + CNT_W'(1))));

    assert_div_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !clr && iclass == 3'd6)
            |=> (cycle_raw == CNT_W'($past(cycle_raw) + CNT_W'(34))));

    assert_flow_noslot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !clr && iclass == 3'd7 && taken && !has_slot)
            |=> (cycle_raw == CNT_W'($past(cycle_raw) + CNT_W'(3))));

    assert_report_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_raw == '0) |-> (cycle_report == '0));
endmodule

// File: tb/sim_pcost_accum.sv
`timescale 1ns/1ps
module sim_pcost_accum;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        retire = 1'b0;
    logic        retire1 = 1'b0;
    logic [2:0]  iclass = 3'd0;
    logic        taken = 1'b0;
    logic        has_slot = 1'b0;
    logic [31:0] inst_count, cycle_raw, cycle_report;
    logic [7:0]  inst1, cyc1, rep1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] e_inst = 0;
    logic [31:0] e_cyc  = 0;

    always #10 clk = ~clk;

    pcost_accum u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .retire(retire), .iclass(iclass),
        .taken(taken), .has_slot(has_slot), .inst_count(inst_count),
        .cycle_raw(cycle_raw), .cycle_report(cycle_report)
    );

    // Narrow copy used only to reach the wrap boundary quickly (R11).
    pcost_accum #(.CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .retire(retire1), .iclass(iclass),
        .taken(taken), .has_slot(has_slot), .inst_count(inst1),
        .cycle_raw(cyc1), .cycle_report(rep1)
    );

    // Entry: {req[3:0], class[2:0], taken, slot, cost[5:0]}
    localparam int NV = 14;
    localparam logic [14:0] VEC [NV] = '{
        {4'd1, 3'd0, 1'b0, 1'b0, 6'd1},   // R1 ALU
        {4'd6, 3'd0, 1'b1, 1'b1, 6'd1},   // R6 ALU flags ignored
        {4'd2, 3'd1, 1'b0, 1'b0, 6'd2},   // R2 load
        {4'd2, 3'd2, 1'b1, 1'b0, 6'd2},   // R2 store with taken set
        {4'd3, 3'd3, 1'b0, 1'b0, 6'd2},   // R3 multiply
        {4'd3, 3'd4, 1'b0, 1'b1, 6'd2},   // R3 barrel shift
        {4'd3, 3'd5, 1'b1, 1'b1, 6'd2},   // R3 custom
        {4'd4, 3'd6, 1'b0, 1'b0, 6'd34},  // R4 divide
        {4'd6, 3'd6, 1'b1, 1'b0, 6'd34},  // R6 divide flags ignored
        {4'd5, 3'd7, 1'b0, 1'b0, 6'd1},   // R5 not taken
        {4'd5, 3'd7, 1'b0, 1'b1, 6'd1},   // R5 not taken, slot set
        {4'd5, 3'd7, 1'b1, 1'b1, 6'd2},   // R5 taken with slot
        {4'd5, 3'd7, 1'b1, 1'b0, 6'd3},   // R5 taken without slot
        {4'd6, 3'd1, 1'b1, 1'b1, 6'd2}    // R6 load flags ignored
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present one cycle of stimulus at a falling edge; results are ready at the next.
    task automatic cyc(input logic r, input logic r1, input logic c,
                       input logic [2:0] k, input logic t, input logic s);
        @(negedge clk);
        retire = r; retire1 = r1; clr = c; iclass = k; taken = t; has_slot = s;
        @(negedge clk);
        retire = 1'b0; retire1 = 1'b0; clr = 1'b0;
    endtask

    function automatic logic [31:0] rep_of(input logic [31:0] raw);
        return (raw == 0) ? 32'd0 : raw + 32'd2;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9", "inst after reset", inst_count, 0);
        chk("R9", "cycle after reset", cycle_raw, 0);
        chk("R7", "report at zero", cycle_report, 0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i][14:11]);
            cyc(1'b1, 1'b0, 1'b0, VEC[i][10:8], VEC[i][7], VEC[i][6]);
            e_inst = e_inst + 1;
            e_cyc  = e_cyc + 32'(VEC[i][5:0]);
            chk(rq, "inst count", inst_count, e_inst);
            chk(rq, "cycle raw", cycle_raw, e_cyc);
            chk("R7", "report", cycle_report, rep_of(e_cyc));
        end

        // R10: idle cycles hold
        cyc(1'b0, 1'b0, 1'b0, 3'd6, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 1'b0);
        chk("R10", "inst idle", inst_count, e_inst);
        chk("R10", "cycle idle", cycle_raw, e_cyc);

        // R8: clear beats a simultaneous retire
        cyc(1'b1, 1'b0, 1'b1, 3'd6, 1'b0, 1'b0);
        chk("R8", "inst after clr", inst_count, 0);
        chk("R8", "cycle after clr", cycle_raw, 0);
        chk("R7", "report after clr", cycle_report, 0);

        // R1 after clear: one divide, then the report bias
        cyc(1'b1, 1'b0, 1'b0, 3'd6, 1'b0, 1'b0);
        chk("R4", "divide after clr", cycle_raw, 34);
        chk("R7", "report of 34", cycle_report, 36);

        // R9: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R9", "inst after mid reset", inst_count, 0);
        chk("R9", "cycle after mid reset", cycle_raw, 0);

        // R11: wrap on the 8-bit copy, 260 ALU retires
        @(negedge clk);
        retire1 = 1'b1; iclass = 3'd0; taken = 1'b0; has_slot = 1'b0;
        repeat (260) @(negedge clk);
        retire1 = 1'b0;
        @(negedge clk);
        chk("R11", "narrow inst wrap", 32'(inst1), 4);
        chk("R11", "narrow cycle wrap", 32'(cyc1), 4);
        chk("R7", "narrow report", 32'(rep1), 6);
        chk("R10", "wide copy untouched", inst_count, 0);

        // R11: eight divides wrap the 8-bit cycle counter (272 mod 256)
        cyc(1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0);
        for (int j = 0; j < 8; j++) cyc(1'b0, 1'b1, 1'b0, 3'd6, 1'b0, 1'b0);
        chk("R11", "narrow divide wrap", 32'(cyc1), 16);
        chk("R11", "narrow inst after divides", 32'(inst1), 8);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule